// File: doc/BRIEF.md
# Board-Local Scan-Out Comparator

This block sits on each board that hangs off a shared multi-drop scan bus. While the TAP is in a shift state, the bus no longer uses the test-data-out line as an output. The controller drives it with the bit it expects to see, and it drives the reset line with a per-bit mask. The block compares every bit that leaves the board's selected local scan path with that expected bit, unless the mask bit excludes it. It keeps a sticky failure flag and a count of the compared shift cycles that came before the first failing bit. Because every board checks its own data, many similar boards can run the same vectors at once.

A small configuration register is written over the scan interface. It turns comparison on, arms the brake for failures, and selects single-board mode. In single-board mode the board returns its scan-out on the test-data-out line during shifts and does no local comparison. The brake opens the local scan paths after the first failure, or when the controller signals the end of a sequence, so that the failing state stays in place for diagnosis. Only a configuration write with the release bit set lifts it. The failure flag and the count are presented in parallel for the results data register to capture.

Top module: `scan_cmp_unit`

## Requirements
- R1: After `rst_n` is asserted low: `fail` = 0, `fail_cnt` = 0, `path_en` = 1, `tdo_oe` = 0, and all configuration bits are 0.
- R2: A compared cycle has `shift_active`=1, enable bit (cfg bit 0)=1, single-board bit (cfg bit 2)=0 and no brake. In such a cycle, with `mask_in`=0 and `scan_out`≠`exp_in`, `fail` reads 1 after that rising TCK edge.
- R3: A compared cycle with `mask_in`=1 never sets `fail`, whatever the data.
- R4: Each compared cycle before the first failure adds one to `fail_cnt`, so `fail_cnt` equals the index of the first failing bit. The failing cycle and every later cycle leave it unchanged, and it saturates at its maximum value.
- R5: A configuration write (`cfg_wr`) or `tlr` clears `fail` and `fail_cnt` at that edge.
- R6: When the brake-on-fail bit (cfg bit 1) is set, a failing compare engages the brake: `path_en` reads 0 after that edge.
- R7: `seq_end` high while the enable bit is set engages the brake at that edge.
- R8: Once engaged, the brake holds through `tlr` and through configuration writes whose release bit (cfg_data bit 3) is 0. No comparison or counting takes place while it holds. A write with bit 3 = 1 releases it.
- R9: In single-board mode, `tdo_oe` equals `shift_active`, `tdo_o` follows `scan_out`, and no comparison is made. In any other mode `tdo_oe` is 0.
- R10: No comparison or counting takes place when the enable bit is 0 or `shift_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_active | input | 1 | TAP is in Shift-DR or Shift-IR |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| scan_out | input | 1 | Bit leaving the selected local scan path |
| exp_in | input | 1 | Expected bit received on the turned-around data-out pad |
| mask_in | input | 1 | Mask bit received on the reset pad during shifts |
| cfg_wr | input | 1 | Configuration register update strobe |
| cfg_data | input | CFG_W | Configuration value: bit0 enable, bit1 brake on fail, bit2 single-board, bit3 release brake |
| seq_end | input | 1 | End-of-sequence brake request |
| tdo_oe | output | 1 | Drive the data-out pad |
| tdo_o | output | 1 | Value driven on the data-out pad |
| path_en | output | 1 | Local scan paths connected (0 = brake engaged) |
| fail | output | 1 | Sticky failure flag |
| fail_cnt | output | CNT_W | Compared cycles before the first failure |

## Verification
The hardest case to reach is the interplay of the brake with clearing. The stimulus first engages the brake with a failure. It then issues a configuration write with the release bit clear, which wipes the results, and drives mismatching shifts and a Test-Logic-Reset while the brake holds. The flag must stay clear and the paths must stay open. Count saturation is reached only by a run of several hundred matching compared cycles, which the bench drives in one long shift.

// File: rtl/scan_cmp_unit.sv
module scan_cmp_unit #(
  parameter int CNT_W = 8,
  parameter int CFG_W = 4
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             shift_active,
  input  logic             tlr,
  input  logic             scan_out,
  input  logic             exp_in,
  input  logic             mask_in,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             seq_end,
  output logic             tdo_oe,
  output logic             tdo_o,
  output logic             path_en,
  output logic             fail,
  output logic [CNT_W-1:0] fail_cnt
);
  localparam int B_EN   = 0;
  localparam int B_BOF  = 1;
  localparam int B_SOLO = 2;
  localparam int B_REL  = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CFG_W-1:0] cfg_q;
  logic             fail_q, brake_q;
  logic [CNT_W-1:0] cnt_q;

  wire en_w     = cfg_q[B_EN];
  wire solo_w   = cfg_q[B_SOLO];
  wire cmp_live = shift_active & en_w & ~solo_w & ~brake_q;
  wire mismatch = cmp_live & ~mask_in & (scan_out ^ exp_in);
  wire clr      = cfg_wr | tlr;

  assign tdo_oe   = shift_active & solo_w;
  assign tdo_o    = scan_out;
  assign path_en  = ~brake_q;
  assign fail     = fail_q;
  assign fail_cnt = cnt_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      fail_q  <= 1'b0;
      cnt_q   <= '0;
      brake_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_data;
      if (clr) begin
        fail_q <= 1'b0;
        cnt_q  <= '0;
      end else if (cmp_live && !fail_q) begin
        if (mismatch)            fail_q <= 1'b1;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (cfg_wr && cfg_data[B_REL])
        brake_q <= 1'b0;
      else if ((mismatch && cfg_q[B_BOF]) || (seq_end && en_w))
        brake_q <= 1'b1;
    end
  end

  // R3
  mask_blocks_fail_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (!fail_q && mask_in) |=> !fail_q);
  // R5
  clear_results_chk: assert property (@(posedge tck) disable iff (!rst_n)
    clr |=> (!fail_q && cnt_q == '0));
  // R4
  count_frozen_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (fail_q && !clr) |=> $stable(cnt_q));
  // R8
  brake_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (brake_q && !(cfg_wr && cfg_data[B_REL])) |=> brake_q);
  // R9
  solo_no_cmp_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (solo_w && !cfg_wr && !tlr) |=> $stable(fail_q));
endmodule

// File: tb/scan_cmp_unit_tb.sv
module scan_cmp_unit_tb;
  localparam int CNT_W = 8;
  localparam int CFG_W = 4;

  logic tck = 0, rst_n = 0;
  logic shift_active = 0, tlr = 0, scan_out = 0, exp_in = 0, mask_in = 0;
  logic cfg_wr = 0, seq_end = 0;
  logic [CFG_W-1:0] cfg_data = '0;
  logic tdo_oe, tdo_o, path_en, fail;
  logic [CNT_W-1:0] fail_cnt;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  int  m_cfg = 0, m_cnt = 0;
  bit  m_fail = 0, m_brake = 0;

  always #5 tck = ~tck;

  scan_cmp_unit #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_dut (
    .tck(tck), .rst_n(rst_n), .shift_active(shift_active), .tlr(tlr),
    .scan_out(scan_out), .exp_in(exp_in), .mask_in(mask_in),
    .cfg_wr(cfg_wr), .cfg_data(cfg_data), .seq_end(seq_end),
    .tdo_oe(tdo_oe), .tdo_o(tdo_o), .path_en(path_en),
    .fail(fail), .fail_cnt(fail_cnt));

  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg <= 0; m_cnt <= 0; m_fail <= 0; m_brake <= 0;
    end else begin
      bit live, bad;
      live = shift_active && m_cfg[0] && !m_cfg[2] && !m_brake;
      bad  = live && !mask_in && (scan_out != exp_in);
      if (cfg_wr) m_cfg <= int'(cfg_data);
      if (cfg_wr || tlr) begin
        m_fail <= 0; m_cnt <= 0;
      end else if (live && !m_fail) begin
        if (bad) m_fail <= 1;
        else if (m_cnt < (1 << CNT_W) - 1) m_cnt <= m_cnt + 1;
      end
      if (cfg_wr && cfg_data[3]) m_brake <= 0;
      else if ((bad && m_cfg[1]) || (seq_end && m_cfg[0])) m_brake <= 1;
    end
  end

  task automatic compare();
    bit e_oe, e_o;
    e_oe = shift_active && m_cfg[2];
    e_o  = scan_out;
    checks++;
    if (fail !== m_fail || int'(fail_cnt) != m_cnt || path_en !== !m_brake ||
        tdo_oe !== e_oe || (e_oe && tdo_o !== e_o)) begin
      errors++;
      $display("FAIL %s t=%0t actual fail=%b cnt=%0d path_en=%b oe=%b o=%b expected fail=%b cnt=%0d path_en=%b oe=%b o=%b",
               tag, $time, fail, fail_cnt, path_en, tdo_oe, tdo_o,
               m_fail, m_cnt, !m_brake, e_oe, e_o);
    end
  endtask

  task automatic cyc(input bit sh, input bit so, input bit ex, input bit mk);
    shift_active = sh; scan_out = so; exp_in = ex; mask_in = mk;
    @(negedge tck);
    compare();
    shift_active = 0; tlr = 0; cfg_wr = 0; seq_end = 0;
  endtask

  task automatic wcfg(input logic [CFG_W-1:0] v);
    cfg_wr = 1; cfg_data = v;
    cyc(0, 0, 0, 0);
  endtask

  initial begin
    @(negedge tck); @(negedge tck);
    tag = "R1"; compare();
    rst_n = 1;
    cyc(0, 0, 0, 0);

    tag = "R2_R4"; wcfg(4'b0001);
    for (int i = 0; i < 5; i++) cyc(1, i[0], i[0], 0);
    tag = "R3";
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 1);
    tag = "R2";  cyc(1, 1, 0, 0);
    tag = "R4";
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0);

    tag = "R5"; tlr = 1; cyc(0, 0, 0, 0);
    tag = "R10";
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
    cyc(1, 1, 1, 0);
    tag = "R5"; cyc(1, 0, 1, 0);
    wcfg(4'b0001);

    tag = "R6"; wcfg(4'b0011);
    cyc(1, 0, 0, 0); cyc(1, 1, 0, 0); cyc(0, 0, 0, 0);
    tag = "R8"; wcfg(4'b0011);
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0);
    tlr = 1; cyc(0, 0, 0, 0);
    cyc(1, 0, 1, 0);
    wcfg(4'b1011);
    cyc(1, 0, 0, 0); cyc(1, 1, 1, 0);

    tag = "R7"; seq_end = 1; cyc(0, 0, 0, 0);
    cyc(1, 1, 0, 0);
    wcfg(4'b1000);
    seq_end = 1; cyc(0, 0, 0, 0);

    tag = "R9"; wcfg(4'b0101);
    for (int i = 0; i < 6; i++) cyc(1, i[1], i[0], 0);
    cyc(0, 1, 0, 0);

    tag = "R10"; wcfg(4'b0000);
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0);

    tag = "R4_sat"; wcfg(4'b0001);
    for (int i = 0; i < 300; i++) cyc(1, i[2], i[2], 0);
    cyc(1, 1, 0, 0); cyc(1, 0, 0, 0);

    tag = "mix";
    for (int i = 0; i < 200; i++) begin
      if (i % 50 == 0) begin cfg_wr = 1; cfg_data = 4'(i % 4) | 4'b1001; end
      if (i % 37 == 0) tlr = 1;
      if (i % 61 == 60) seq_end = 1;
      cyc(i % 5 != 0, i[1] ^ i[3], i[1], i % 7 == 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule